// File: doc/BRIEF.md
# Segment Store Request Sequencer

This block takes one unit-stride segment store command at a time and turns it into an ordered stream of requests for the vector memory pipeline. A command names a base address, an element count, an element width, a field-count code, a masking enable, a mask register image, a register-group multiplier code, and two status flags: whether the vector unit is enabled, and whether the vector type is marked invalid. VLEN is fixed by a parameter.

The work is cut into chunks that each fit in one vector register. The sequencer first emits one interleave step per (field, chunk) pair, which tells the datapath to build that chunk. It then emits one store request per pair. Each store request carries an address, a byte size and per-byte write enables. Field is the outer loop and chunk the inner loop in both passes. A command that is illegal is rejected before anything is issued. A command with zero length produces a single no-op. Every request waits on a valid/ready handshake, and a one-cycle done pulse closes the command.

Top module: `seg_store_seq`

## Requirements
- R1: After reset, req_valid, done and fault are low and cmd_ready is high.
- R2: An accepted command with cmd_vu_on low or cmd_vill high pulses fault for one cycle, in the cycle after acceptance, and produces no request.
- R3: An accepted command is illegal, and behaves as in R2, when cmd_lmul is 4 (reserved) or when cmd_lmul is 0..3 and (cmd_nf+1) shifted left by cmd_lmul exceeds 8. Codes 5..7 are fractional multipliers and are always legal.
- R4: A legal command with cmd_vl of 0 issues exactly one request of kind NOP (req_kind 0), with req_size 0 and req_be 0.
- R5: With cmd_nf from 1 to 7 there are NF = cmd_nf+1 fields. The block issues NF×C interleave steps (req_kind 1) and then NF×C stores (req_kind 2), where C is the chunk count. Within each pass req_field is the outer loop and req_chunk the inner loop. With cmd_nf of 0 only the C stores of field 0 are issued.
- R6: The element width is 8<<cmd_ew bits. Elements per chunk E = VLEN/width, C = ceil(vl/E), and chunk c holds min(vl − c·E, E) elements. req_size is that count times the element byte width, for interleave steps and stores alike.
- R7: A store's req_addr is cmd_base + req_size × (chunk + field × C). Other kinds drive req_addr 0.
- R8: With cmd_unmasked high, a store enables the low req_size bytes of req_be and no others.
- R9: With cmd_unmasked low, element e of chunk c in field f is active exactly when cmd_mask bit floor((c·E + e + f·n)/NF) is set, where n is the chunk's element count. A mask index at or beyond VLEN reads as 0. An active element enables all of its bytes, and an inactive one enables none.
- R10: While req_valid is high and req_ready is low, every request output holds its value.
- R11: done pulses for one cycle, in the cycle after the final request is accepted. cmd_ready is low while requests are pending.
- R12: Interleave steps and no-ops always drive req_be to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted on valid |
| cmd_base | input | AW | Base byte address |
| cmd_vl | input | VLW | Element count |
| cmd_ew | input | 2 | Element width code, 8<<code bits |
| cmd_nf | input | 3 | Field-count code, 0 = plain store |
| cmd_unmasked | input | 1 | High: ignore mask |
| cmd_mask | input | VLEN | Mask register image |
| cmd_lmul | input | 3 | Register-group multiplier code |
| cmd_vu_on | input | 1 | Vector unit enabled |
| cmd_vill | input | 1 | Vector type invalid |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request taken |
| req_kind | output | 2 | 0 no-op, 1 interleave, 2 store |
| req_field | output | 3 | Field index |
| req_chunk | output | VLW | Chunk index |
| req_addr | output | AW | Store byte address |
| req_size | output | SZW | Chunk byte size |
| req_be | output | VLEN/8 | Per-byte write enables |
| done | output | 1 | Command finished pulse |
| fault | output | 1 | Illegal command pulse |

## Verification
A corrupted field or chunk counter shows up on the very next request, as a wrong req_field/req_chunk pair and a shifted req_addr. A wrong chunk-count decode shows as a missing or extra request at a pass boundary, or as done arriving a cycle early or late. Mask-index errors stay hidden until a masked store is issued, and then appear as wrong req_be bits. For this reason the bench compares every request of several masked multi-field commands in full.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [1:0] {
        KIND_NOP   = 2'd0,
        KIND_ILV   = 2'd1,
        KIND_STORE = 2'd2
    } seg_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_NOP   = 2'd1,
        PH_ILV   = 2'd2,
        PH_STORE = 2'd3
    } seg_phase_e;
endpackage

// File: rtl/seg_cmd_check.sv
module seg_cmd_check (
    input  logic [2:0] nf,
    input  logic [2:0] lmul,
    input  logic       vu_on,
    input  logic       vill,
    output logic       illegal
);
    logic [3:0] nfields;
    logic [7:0] group_regs;
    logic       bad_group;

    always_comb begin
        nfields    = {1'b0, nf} + 4'd1;
        group_regs = 8'({4'd0, nfields} << lmul[1:0]);
        bad_group  = 1'b0;
        if (lmul == 3'd4)
            bad_group = 1'b1;
        else if (!lmul[2])
            bad_group = (group_regs > 8'd8);
        illegal = !vu_on || vill || bad_group;
    end
endmodule

// File: rtl/seg_chunk_calc.sv
module seg_chunk_calc #(
    parameter int VLEN = 128,
    parameter int AW   = 32,
    localparam int VLENB = VLEN / 8,
    localparam int LB    = $clog2(VLENB),
    localparam int VLW   = $clog2(VLEN) + 1,
    localparam int SZW   = $clog2(VLENB) + 1
) (
    input  logic [AW-1:0]  base,
    input  logic [VLW-1:0] vl,
    input  logic [1:0]     ew,
    input  logic [2:0]     field,
    input  logic [VLW-1:0] chunk,
    output logic [2:0]     lg_epc,
    output logic [VLW:0]   nchunks,
    output logic [VLW:0]   chunk_elems,
    output logic [SZW-1:0] size,
    output logic [AW-1:0]  addr
);
    logic [VLW:0]   epc;
    logic [VLW:0]   offs;
    logic [VLW:0]   rem;
    logic [VLW+3:0] bytes_w;
    logic [AW-1:0]  slot;

    always_comb begin
        lg_epc      = 3'(LB) - {1'b0, ew};
        epc         = (VLW+1)'(1) << lg_epc;
        nchunks     = ({1'b0, vl} + epc - (VLW+1)'(1)) >> lg_epc;
        offs        = {1'b0, chunk} << lg_epc;
        rem         = {1'b0, vl} - offs;
        chunk_elems = (rem > epc) ? epc : rem;
        bytes_w     = (VLW+4)'(chunk_elems) << ew;
        size        = SZW'(bytes_w);
        slot        = AW'(chunk) + AW'(field) * AW'(nchunks);
        addr        = base + AW'(size) * slot;
    end
endmodule

// File: rtl/seg_byte_en.sv
module seg_byte_en #(
    parameter int VLEN = 128,
    localparam int VLENB = VLEN / 8,
    localparam int VLW   = $clog2(VLEN) + 1,
    localparam int IW    = VLW + 5,
    localparam int MIW   = $clog2(VLEN)
) (
    input  logic [1:0]       ew,
    input  logic [2:0]       nf,
    input  logic             unmasked,
    input  logic [VLEN-1:0]  mask,
    input  logic [2:0]       lg_epc,
    input  logic [2:0]       field,
    input  logic [VLW-1:0]   chunk,
    input  logic [VLW:0]     chunk_elems,
    output logic [VLENB-1:0] be
);
    logic [VLENB-1:0] elem_on;
    logic [IW-1:0]    nfields;

    assign nfields = IW'(nf) + IW'(1);

    for (genvar e = 0; e < VLENB; e++) begin : g_elem
        logic [IW-1:0] idx;
        logic [IW-1:0] rec;
        logic          mbit;
        always_comb begin
            idx  = (IW'(chunk) << lg_epc) + IW'(e) + IW'(field) * IW'(chunk_elems);
            rec  = idx / nfields;
            mbit = (rec < IW'(VLEN)) ? mask[rec[MIW-1:0]] : 1'b0;
            elem_on[e] = ((VLW+1)'(e) < chunk_elems) && (unmasked || mbit);
        end
    end

    always_comb begin
        for (int b = 0; b < VLENB; b++)
            be[b] = elem_on[b >> ew];
    end
endmodule

// File: rtl/seg_store_seq.sv
module seg_store_seq #(
    parameter int VLEN = 128,
    parameter int AW   = 32,
    localparam int VLENB = VLEN / 8,
    localparam int VLW   = $clog2(VLEN) + 1,
    localparam int SZW   = $clog2(VLENB) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [AW-1:0]    cmd_base,
    input  logic [VLW-1:0]   cmd_vl,
    input  logic [1:0]       cmd_ew,
    input  logic [2:0]       cmd_nf,
    input  logic             cmd_unmasked,
    input  logic [VLEN-1:0]  cmd_mask,
    input  logic [2:0]       cmd_lmul,
    input  logic             cmd_vu_on,
    input  logic             cmd_vill,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [1:0]       req_kind,
    output logic [2:0]       req_field,
    output logic [VLW-1:0]   req_chunk,
    output logic [AW-1:0]    req_addr,
    output logic [SZW-1:0]   req_size,
    output logic [VLENB-1:0] req_be,
    output logic             done,
    output logic             fault
);
    import seg_pkg::*;

    typedef struct packed {
        seg_phase_e      phase;
        logic [2:0]      field;
        logic [VLW-1:0]  chunk;
        logic [AW-1:0]   base;
        logic [VLW-1:0]  vl;
        logic [1:0]      ew;
        logic [2:0]      nf;
        logic            unmasked;
        logic [VLEN-1:0] mask;
        logic            done;
        logic            fault;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic             illegal;
    logic [2:0]       lg_epc;
    logic [VLW:0]     nchunks;
    logic [VLW:0]     chunk_elems;
    logic [SZW-1:0]   size;
    logic [AW-1:0]    addr;
    logic [VLENB-1:0] be;
    logic             last_chunk;
    logic             last_field;

    seg_cmd_check u_check (
        .nf      (cmd_nf),
        .lmul    (cmd_lmul),
        .vu_on   (cmd_vu_on),
        .vill    (cmd_vill),
        .illegal (illegal)
    );

    seg_chunk_calc #(.VLEN(VLEN), .AW(AW)) u_calc (
        .base        (st_q.base),
        .vl          (st_q.vl),
        .ew          (st_q.ew),
        .field       (st_q.field),
        .chunk       (st_q.chunk),
        .lg_epc      (lg_epc),
        .nchunks     (nchunks),
        .chunk_elems (chunk_elems),
        .size        (size),
        .addr        (addr)
    );

    seg_byte_en #(.VLEN(VLEN)) u_be (
        .ew          (st_q.ew),
        .nf          (st_q.nf),
        .unmasked    (st_q.unmasked),
        .mask        (st_q.mask),
        .lg_epc      (lg_epc),
        .field       (st_q.field),
        .chunk       (st_q.chunk),
        .chunk_elems (chunk_elems),
        .be          (be)
    );

    assign last_chunk = ({1'b0, st_q.chunk} == nchunks - (VLW+1)'(1));
    assign last_field = (st_q.field == st_q.nf);

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (illegal) begin
                        st_d.fault = 1'b1;
                    end else begin
                        st_d.base     = cmd_base;
                        st_d.vl       = cmd_vl;
                        st_d.ew       = cmd_ew;
                        st_d.nf       = cmd_nf;
                        st_d.unmasked = cmd_unmasked;
                        st_d.mask     = cmd_mask;
                        st_d.field    = 3'd0;
                        st_d.chunk    = '0;
                        if (cmd_vl == '0)
                            st_d.phase = PH_NOP;
                        else if (cmd_nf != 3'd0)
                            st_d.phase = PH_ILV;
                        else
                            st_d.phase = PH_STORE;
                    end
                end
            end
            PH_NOP: begin
                if (req_ready) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: begin
                if (req_ready) begin
                    if (!last_chunk) begin
                        st_d.chunk = st_q.chunk + VLW'(1);
                    end else begin
                        st_d.chunk = '0;
                        if (!last_field) begin
                            st_d.field = st_q.field + 3'd1;
                        end else begin
                            st_d.field = 3'd0;
                            if (st_q.phase == PH_ILV) begin
                                st_d.phase = PH_STORE;
                            end else begin
                                st_d.phase = PH_IDLE;
                                st_d.done  = 1'b1;
                            end
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        cmd_ready = (st_q.phase == PH_IDLE);
        req_valid = (st_q.phase != PH_IDLE);
        req_field = st_q.field;
        req_chunk = st_q.chunk;
        req_kind  = KIND_NOP;
        req_addr  = '0;
        req_be    = '0;
        req_size  = '0;
        if (st_q.phase == PH_ILV) begin
            req_kind = KIND_ILV;
            req_size = size;
        end else if (st_q.phase == PH_STORE) begin
            req_kind = KIND_STORE;
            req_size = size;
            req_addr = addr;
            req_be   = be;
        end
        done  = st_q.done;
        fault = st_q.fault;
    end
endmodule

// File: rtl/seg_store_seq_chk.sv
module seg_store_seq_chk #(
    parameter int VLEN = 128,
    parameter int AW   = 32,
    localparam int VLENB = VLEN / 8,
    localparam int VLW   = $clog2(VLEN) + 1,
    localparam int SZW   = $clog2(VLENB) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_kind,
    input logic [2:0]       req_field,
    input logic [VLW-1:0]   req_chunk,
    input logic [AW-1:0]    req_addr,
    input logic [SZW-1:0]   req_size,
    input logic [VLENB-1:0] req_be,
    input logic             done,
    input logic             fault
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_be)
            && $stable(req_kind) && $stable(req_field) && $stable(req_chunk) && $stable(req_size)); // R10
    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !req_valid && !done); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && req_ready)); // R11
    AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cmd_ready); // R11
    AST_NONSTORE_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind != 2'd2 |-> req_be == '0); // R12
    AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_size <= SZW'(VLENB)); // R6
endmodule

bind seg_store_seq seg_store_seq_chk #(.VLEN(VLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_field (req_field),
    .req_chunk (req_chunk),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_be    (req_be),
    .done      (done),
    .fault     (fault)
);

// File: tb/seg_store_seq_bench.sv
module seg_store_seq_bench;
    localparam int VLEN  = 128;
    localparam int AW    = 32;
    localparam int VLENB = VLEN / 8;
    localparam int VLW   = $clog2(VLEN) + 1;
    localparam int SZW   = $clog2(VLENB) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [AW-1:0]    cmd_base = '0;
    logic [VLW-1:0]   cmd_vl = '0;
    logic [1:0]       cmd_ew = '0;
    logic [2:0]       cmd_nf = '0;
    logic             cmd_unmasked = 1'b1;
    logic [VLEN-1:0]  cmd_mask = '0;
    logic [2:0]       cmd_lmul = '0;
    logic             cmd_vu_on = 1'b1;
    logic             cmd_vill = 1'b0;
    logic             req_valid;
    logic             req_ready = 1'b1;
    logic [1:0]       req_kind;
    logic [2:0]       req_field;
    logic [VLW-1:0]   req_chunk;
    logic [AW-1:0]    req_addr;
    logic [SZW-1:0]   req_size;
    logic [VLENB-1:0] req_be;
    logic             done;
    logic             fault;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    seg_store_seq #(.VLEN(VLEN), .AW(AW)) u_seg_store_seq (.*);

    typedef struct packed {
        logic [7:0]  vl;
        logic [1:0]  ew;
        logic [2:0]  nf;
        logic        unm;
        logic [2:0]  lmul;
        logic        vu_on;
        logic        vill;
        logic [31:0] mask;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'd5,  2'd0, 3'd0, 1'b1, 3'd0, 1'b1, 1'b0, 32'h0},
        '{8'd20, 2'd0, 3'd1, 1'b1, 3'd1, 1'b1, 1'b0, 32'h0},
        '{8'd6,  2'd2, 3'd2, 1'b0, 3'd1, 1'b1, 1'b0, 32'hA5C3_0F69},
        '{8'd3,  2'd3, 3'd7, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0000_00B7},
        '{8'd9,  2'd1, 3'd3, 1'b1, 3'd2, 1'b1, 1'b0, 32'h0},
        '{8'd4,  2'd0, 3'd1, 1'b1, 3'd0, 1'b0, 1'b0, 32'h0},
        '{8'd4,  2'd0, 3'd1, 1'b1, 3'd0, 1'b1, 1'b1, 32'h0},
        '{8'd4,  2'd0, 3'd0, 1'b1, 3'd4, 1'b1, 1'b0, 32'h0},
        '{8'd4,  2'd1, 3'd7, 1'b0, 3'd7, 1'b1, 1'b0, 32'h3C96_E01D},
        '{8'd0,  2'd0, 3'd2, 1'b1, 3'd0, 1'b1, 1'b0, 32'h0}
    };

    task automatic check(input bit ok, input string req, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic bit exp_fault(input vec_t v);
        int nfl = int'(v.nf) + 1;
        if (!v.vu_on || v.vill) return 1'b1;
        if (v.lmul == 3'd4) return 1'b1;
        if (v.lmul < 3'd4 && (nfl << v.lmul) > 8) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int exp_count(input vec_t v);
        int bytes = 1 << v.ew;
        int epc = VLENB / bytes;
        int nch = (int'(v.vl) + epc - 1) / epc;
        int nfl = int'(v.nf) + 1;
        if (v.vl == 0) return 1;
        return (v.nf != 0) ? 2 * nfl * nch : nch;
    endfunction

    task automatic exp_req(input vec_t v, input logic [AW-1:0] base, input int k,
                           output logic [1:0] kind, output int f, output int c,
                           output logic [AW-1:0] addr, output int size,
                           output logic [VLENB-1:0] be);
        int bytes = 1 << v.ew;
        int epc = VLENB / bytes;
        int nch = (int'(v.vl) + epc - 1) / epc;
        int nfl = int'(v.nf) + 1;
        int j = k;
        int mvl;
        logic [VLEN-1:0] m = {4{v.mask}};
        be = '0; addr = '0; f = 0; c = 0; size = 0;
        if (v.vl == 0) begin
            kind = 2'd0;
            return;
        end
        if (v.nf != 0 && j < nfl * nch) begin
            kind = 2'd1;
        end else begin
            kind = 2'd2;
            if (v.nf != 0) j = j - nfl * nch;
        end
        f = j / nch;
        c = j % nch;
        mvl = (int'(v.vl) - c * epc < epc) ? int'(v.vl) - c * epc : epc;
        size = mvl * bytes;
        if (kind == 2'd2) begin
            addr = base + AW'(size * (c + f * nch));
            for (int e = 0; e < mvl; e++) begin
                int rec = (c * epc + e + f * mvl) / nfl;
                bit on = v.unm || (rec < VLEN && m[rec] == 1'b1);
                for (int b = 0; b < bytes; b++)
                    be[e * bytes + b] = on;
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input logic [AW-1:0] base, input int stall);
        int n;
        @(negedge clk);
        cmd_base = base; cmd_vl = VLW'(v.vl); cmd_ew = v.ew; cmd_nf = v.nf;
        cmd_unmasked = v.unm; cmd_mask = {4{v.mask}}; cmd_lmul = v.lmul;
        cmd_vu_on = v.vu_on; cmd_vill = v.vill; cmd_valid = 1'b1; req_ready = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (exp_fault(v)) begin
            check(fault === 1'b1 && req_valid === 1'b0, v.lmul[2] || !v.vu_on || v.vill ? "R2" : "R3",
                  $sformatf("fault=%0b req_valid=%0b exp fault=1 req_valid=0", fault, req_valid));
            @(negedge clk);
            check(fault === 1'b0 && req_valid === 1'b0 && done === 1'b0, "R2",
                  $sformatf("after fault: fault=%0b req_valid=%0b done=%0b exp 0/0/0", fault, req_valid, done));
            return;
        end
        n = exp_count(v);
        check(cmd_ready === 1'b0, "R11", $sformatf("cmd_ready=%0b exp 0 while busy", cmd_ready));
        for (int k = 0; k < n; k++) begin
            logic [1:0] ek; int ef; int ec; logic [AW-1:0] ea; int es; logic [VLENB-1:0] eb;
            exp_req(v, base, k, ek, ef, ec, ea, es, eb);
            if (k == 0 && stall > 0) begin
                req_ready = 1'b0;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    check(req_valid === 1'b1 && req_kind === ek && req_chunk === VLW'(ec) && req_size === SZW'(es),
                          "R10", $sformatf("stall kind=%0d chunk=%0d size=%0d exp %0d/%0d/%0d",
                                           req_kind, req_chunk, req_size, ek, ec, es));
                end
                req_ready = 1'b1;
            end
            check(req_valid === 1'b1 && req_kind === ek && req_field === 3'(ef) && req_chunk === VLW'(ec)
                  && req_addr === ea && req_size === SZW'(es) && req_be === eb,
                  ek == 2'd0 ? "R4" : (ek == 2'd1 ? "R5" : (v.unm ? "R7" : "R9")),
                  $sformatf("req %0d: v=%0b kind=%0d f=%0d c=%0d addr=%h size=%0d be=%h exp kind=%0d f=%0d c=%0d addr=%h size=%0d be=%h",
                            k, req_valid, req_kind, req_field, req_chunk, req_addr, req_size, req_be,
                            ek, ef, ec, ea, es, eb));
            @(negedge clk);
        end
        check(done === 1'b1 && req_valid === 1'b0 && cmd_ready === 1'b1, "R11",
              $sformatf("end: done=%0b req_valid=%0b cmd_ready=%0b exp 1/0/1", done, req_valid, cmd_ready));
        @(negedge clk);
        check(done === 1'b0, "R11", $sformatf("done=%0b exp 0 after pulse", done));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_valid === 1'b0 && done === 1'b0 && fault === 1'b0 && cmd_ready === 1'b1, "R1",
              $sformatf("reset: valid=%0b done=%0b fault=%0b ready=%0b exp 0/0/0/1", req_valid, done, fault, cmd_ready));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_valid === 1'b0 && cmd_ready === 1'b1, "R1",
              $sformatf("after reset: valid=%0b ready=%0b exp 0/1", req_valid, cmd_ready));

        for (int i = 0; i < NVEC; i++)
            run_vec(VECS[i], AW'(32'h1000 + i * 32'h100), 0);

        // R10: stall on first interleave step, then full masked sequence
        run_vec(VECS[2], AW'(32'h8000), 3);
        // R8 / R6: plain store, 16-bit elements, several chunks, last one partial
        run_vec('{8'd19, 2'd1, 3'd0, 1'b1, 3'd1, 1'b1, 1'b0, 32'h0}, AW'(32'h4000), 0);
        // R3: boundary that is still legal (2 fields, group of 4 -> 8)
        run_vec('{8'd7, 2'd0, 3'd1, 1'b0, 3'd2, 1'b1, 1'b0, 32'hFFFF_0001}, AW'(32'h5000), 0);
        // R3: just over the bound (3 fields, group of 4 -> 12)
        run_vec('{8'd7, 2'd0, 3'd2, 1'b1, 3'd2, 1'b1, 1'b0, 32'h0}, AW'(32'h6000), 0);
        // R12: interleave steps always have empty enables; covered within each masked run
        run_vec('{8'd2, 2'd0, 3'd3, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0000_0000}, AW'(32'h7000), 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule